// File: doc/BRIEF.md
# Split Divide-by-Two / Divide-by-Eight Counter

This block is a four-bit counter built from two sections, each with its own clock input. The low section is a single toggle stage that divides its clock by two. The high section is a three-bit stage that divides its clock by eight. Each section advances on the falling edge of its own clock. A two-input clear forces both sections to zero. The clear acts only while both of its inputs are high at the same time.

The two sections can be chained to form a modulo-16 counter in two ways. One way is external: wire the low section's output to the high section's clock. The other way is internal: set the `CASCADE` parameter, and the high section then takes its clock from the low bit and ignores its own clock pin. In the chained form, bit 0 is the divide-by-two output and bits 3:1 hold the divide-by-eight count. The four-bit value therefore steps through 0 to 15 in order, one step per falling edge of the low clock.

Top module: `split_div_counter`

## Requirements
- R1: Each falling edge of `clk_lo` inverts `count[0]` when the clear is not active.
- R2: With `CASCADE` = 0, each falling edge of `clk_hi` adds one to `count[3:1]`, and `clk_lo` edges leave `count[3:1]` unchanged.
- R3: While `clr_a` and `clr_b` are both high, `count` is 0. This takes effect at once, without a clock edge, and clock edges seen during that time do not change it.
- R4: When only one of `clr_a` and `clr_b` is high, `count` is unchanged and counting continues as normal.
- R5: `count[3:1]` goes from 7 to 0 on its next clock.
- R6: With `CASCADE` = 1, the high section advances on each falling edge of `count[0]`, and `clk_hi` has no effect. `count` then rises by one, modulo 16, on every falling edge of `clk_lo`, and goes from 15 to 0.
- R7: Rising edges on `clk_lo` and `clk_hi` leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Clock for the divide-by-two section; counts on its falling edge |
| clk_hi | input | 1 | Clock for the divide-by-eight section; counts on its falling edge; ignored when CASCADE=1 |
| clr_a | input | 1 | First clear input, active high |
| clr_b | input | 1 | Second clear input, active high; the clear acts only when both are high |
| count | output | HI_W+1 | Bit 0 is the divide-by-two output; the bits above it are the divide-by-eight count |

## Verification
Two instances share the stimulus. The first is separately clocked, and the second has the internal chain enabled. Pulses on only the low clock tell a correct chain apart from a high section that ignores its clock source. Pulses on only the high clock show that the two sections are independent, and that the chained instance ignores that pin. Clears with a single input active tell AND gating apart from OR gating. A clear raised between clock edges shows that it acts without a clock. Falling edges applied while the clear is held show that the clear dominates. A random mix of pulses and clears over many steps checks the 7-to-0 and 15-to-0 wraps at arbitrary points.

// File: rtl/split_div_counter.sv
module split_div_counter #(
  parameter int HI_W    = 3,
  parameter bit CASCADE = 1'b0
) (
  input  logic          clk_lo,
  input  logic          clk_hi,
  input  logic          clr_a,
  input  logic          clr_b,
  output logic [HI_W:0] count
);
  logic            clr;
  logic            lo_q;
  logic [HI_W-1:0] hi_q;
  logic            hi_clk;

  assign clr = clr_a & clr_b;

  generate
    if (CASCADE) begin : g_chain
      assign hi_clk = lo_q;
    end else begin : g_split
      assign hi_clk = clk_hi;
    end
  endgenerate

  always_ff @(negedge clk_lo or posedge clr) begin
    if (clr) lo_q <= 1'b0;
    else     lo_q <= ~lo_q;
  end

  always_ff @(negedge hi_clk or posedge clr) begin
    if (clr) hi_q <= '0;
    else     hi_q <= hi_q + 1'b1;
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/split_div_counter_chk.sv
module split_div_counter_chk #(
  parameter int HI_W    = 3,
  parameter bit CASCADE = 1'b0
) (
  input logic          clk_lo,
  input logic          clk_hi,
  input logic          clr_a,
  input logic          clr_b,
  input logic [HI_W:0] count
);
  logic            clr;
  logic            m_lo;
  logic [HI_W-1:0] m_hi;
  logic            ck8;

  assign clr = clr_a & clr_b;
  assign ck8 = CASCADE ? count[0] : clk_hi;

  always_ff @(negedge clk_lo or posedge clr) begin
    if (clr) m_lo <= 1'b0;
    else     m_lo <= ~m_lo;
  end

  always_ff @(negedge ck8 or posedge clr) begin
    if (clr) m_hi <= '0;
    else     m_hi <= m_hi + 1'b1;
  end

  assert_div2_R1: assert property (@(posedge clk_lo) disable iff (clr)
    count[0] == m_lo);

  assert_div8_R2: assert property (@(posedge ck8) disable iff (clr)
    count[HI_W:1] == m_hi);

  assert_clear_R3: assert property (@(posedge clk_lo)
    clr |-> count == '0);

  generate
    if (CASCADE) begin : g_chain
      logic [HI_W:0] m_cnt;
      always_ff @(negedge clk_lo or posedge clr) begin
        if (clr) m_cnt <= '0;
        else     m_cnt <= m_cnt + 1'b1;
      end
      assert_chain_R6: assert property (@(posedge clk_lo) disable iff (clr)
        count == m_cnt);
    end
  endgenerate
endmodule

bind split_div_counter split_div_counter_chk #(.HI_W(HI_W), .CASCADE(CASCADE)) chk_i (
  .clk_lo(clk_lo),
  .clk_hi(clk_hi),
  .clr_a (clr_a),
  .clr_b (clr_b),
  .count (count)
);

// File: tb/split_div_counter_tb_top.sv
`timescale 1ns/1ps
module split_div_counter_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clk_lo = 1'b0, clk_hi = 1'b0, clr_a = 1'b1, clr_b = 1'b1;
  logic [3:0] q_split, q_chain;
  int errors = 0, checks = 0;
  logic       r2;
  logic [2:0] r8;
  logic [3:0] r16;

  split_div_counter #(.HI_W(3), .CASCADE(1'b0)) dut_i (
    .clk_lo(clk_lo), .clk_hi(clk_hi), .clr_a(clr_a), .clr_b(clr_b), .count(q_split));
  split_div_counter #(.HI_W(3), .CASCADE(1'b1)) chain_i (
    .clk_lo(clk_lo), .clk_hi(clk_hi), .clr_a(clr_a), .clr_b(clr_b), .count(q_chain));

  function automatic logic [3:0] exp_split();
    return {r8, r2};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_both(input string req);
    @(negedge clk);
    check({req, " split"}, q_split, exp_split());
    check({req, " chain"}, q_chain, r16);
  endtask

  task automatic pulse_lo(input string req);
    @(posedge clk) clk_lo = 1'b1;
    check_both({req, " R7 rise"});
    @(posedge clk) clk_lo = 1'b0;
    if (!(clr_a && clr_b)) begin
      r2 = ~r2;
      r16 = r16 + 4'd1;
    end
    check_both(req);
  endtask

  task automatic pulse_hi(input string req);
    @(posedge clk) clk_hi = 1'b1;
    check_both({req, " R7 rise"});
    @(posedge clk) clk_hi = 1'b0;
    if (!(clr_a && clr_b)) r8 = r8 + 3'd1;
    check_both(req);
  endtask

  task automatic clear_pulse();
    @(posedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    r2 = 1'b0; r8 = '0; r16 = '0;
    check_both("R3 async clear");
    @(posedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    check_both("R3 after release");
  endtask

  task automatic single_clear(input bit which);
    @(posedge clk) if (which) clr_a = 1'b1; else clr_b = 1'b1;
    check_both("R4 single input");
    pulse_lo("R4 count during single");
    @(posedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end
    check_both("R4 after single");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    r2 = 1'b0; r8 = '0; r16 = '0;
    repeat (3) @(posedge clk);
    check_both("R3 reset state");
    pulse_lo("R3 clock under clear");
    pulse_hi("R3 clock under clear");
    @(posedge clk) begin clr_a = 1'b0; clr_b = 1'b0; end

    for (int i = 0; i < 17; i++) pulse_lo("R1 R6 chain wrap");
    for (int i = 0; i < 9; i++) pulse_hi("R2 R5 div8 wrap");
    single_clear(1'b1);
    single_clear(1'b0);
    clear_pulse();

    for (int i = 0; i < 60; i++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 5)      pulse_lo("R1 R6 random");
      else if (op < 7) pulse_hi("R2 R5 random");
      else if (op < 9) single_clear(op[0]);
      else             clear_pulse();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule